// File: doc/BRIEF.md
# Tag Command Frame Parser

This block sits behind the gap demodulator of a 125 kHz read/write identification tag. It takes the reader-to-tag bits one at a time, first bit first, together with an end-of-frame strobe and an interval-error strobe. It keeps a running bit count, takes the first two bits as the opcode, and compares any password bit by bit against stored block 7 while the bits arrive. When the frame closes, it issues a single decision: a write, a direct block read, a reset, a wake-up, a test-mode access, or a fallback to regular read.

Whether a frame is valid depends only on its exact length for the active configuration: password mode on or off, and answer-on-request on or off. The block does not look for delimiters. The payload always closes a frame in the same order: lock bit, 32 data bits, then the 3-bit address. Because of this, the fields sit at fixed positions in a short shift register, whether or not a password came before them. A small array of eight 32-bit blocks, each with a lock bit, stands in for the non-volatile memory. Accepted writes update this array, and direct reads return its contents.

Top module: `tag_cmd_parser`

## Requirements
- R1: The first two bits of a frame are the opcode. A 2-bit frame with opcode 00 yields the reset decision (kind 3) and selects page 0.
- R2: With password mode off, a 38-bit frame of opcode 1p, lock bit, 32 data bits and a 3-bit address yields a write (kind 1). The first data bit to arrive becomes data bit 31, and the first address bit becomes address bit 2. The block and its lock bit in the array take the new values.
- R3: With password mode off, a 6-bit frame of opcode 1p, a 0 bit and a 3-bit address yields a block read (kind 2) on page p. Page 0 returns the stored block, and page 1 returns all zeros.
- R4: With password mode on, 32 password bits follow the opcode. They are checked against block 7, with the first password bit compared to bit 31. A matching 38-bit direct access yields a block read, and a matching 70-bit write yields a write.
- R5: With password mode and answer-on-request both on, a 34-bit frame of opcode 10 and a matching password yields a wake-up (kind 4). In any other configuration, a 34-bit frame falls back to regular read.
- R6: A frame falls back to regular read (kind 5, address 1) on the page that its opcode names in any of these cases: the bit count fits no format for the current modes, an interval error was strobed during the frame, or the password mismatched.
- R7: A valid write is not stored, and yields a block read of the addressed block, in any of these cases: the block's lock bit is set, the one-time-programmable input is high, or the write targets page 1.
- R8: Opcode 01 yields the test decision (kind 6). When the master key input equals 6, the frame produces no decision at all.
- R9: The decision appears as a one-cycle `cmd_valid` pulse in the cycle after `frame_end` is sampled. Kind codes are 1 write, 2 block read, 3 reset, 4 wake-up, 5 regular read, 6 test.
- R10: A 2-bit frame with opcode 1p yields regular read on page p. A frame with fewer than two bits yields regular read on the previously selected page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid_i | input | 1 | A decoded bit is present |
| bit_i | input | 1 | Decoded bit value |
| frame_end_i | input | 1 | Frame closed, asserted in a cycle without a bit |
| frame_err_i | input | 1 | Invalid gap interval seen in the current frame |
| pwd_en_i | input | 1 | Password mode active |
| aor_en_i | input | 1 | Answer-on-request mode active |
| otp_i | input | 1 | Treat every block as locked |
| master_key_i | input | 4 | Master key field of the configuration |
| cmd_valid_o | output | 1 | Decision pulse |
| cmd_kind_o | output | 3 | Decision kind code |
| cmd_page_o | output | 1 | Selected page |
| cmd_addr_o | output | 3 | Block address (1 for regular read) |
| cmd_data_o | output | 32 | Written data or block read contents |
| cmd_lock_o | output | 1 | Lock bit of a write |

## Verification
Some properties are checked on every cycle:
- a decision pulse follows an end-of-frame;
- its kind code is legal;
- a write decision matches what is now in the array;
- a write is never issued while the one-time-programmable input is high or on page 1;
- the test decision never comes out while the master key is 6;
- a wake-up needs both modes on.

Other behaviours can only be shown by the directed scenarios, because they depend on the exact bit order, count and history. These are:
- field extraction;
- the password comparison against block 7;
- the per-count fallbacks;
- lock bits that persist from an earlier write;
- a page choice carried over to a frame that is too short to name one.

// File: rtl/tag_cmd_parser.sv
module tag_cmd_parser #(
  parameter int DW = 32,
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid_i,
  input  logic          bit_i,
  input  logic          frame_end_i,
  input  logic          frame_err_i,
  input  logic          pwd_en_i,
  input  logic          aor_en_i,
  input  logic          otp_i,
  input  logic [3:0]    master_key_i,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_kind_o,
  output logic          cmd_page_o,
  output logic [$clog2(NB)-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o,
  output logic          cmd_lock_o
);
  localparam int AW    = $clog2(NB);
  localparam int OPW   = 2;
  localparam int L_DA  = OPW + 1 + AW;
  localparam int L_DAP = L_DA + DW;
  localparam int L_WK  = OPW + DW;
  localparam int L_WR  = OPW + 1 + DW + AW;
  localparam int L_PWR = L_WR + DW;
  localparam int CW    = $clog2(L_PWR + 1) + 1;
  localparam int SRW   = AW + DW + 1;
  localparam int PIW   = $clog2(DW);

  localparam logic [2:0] K_WRITE = 3'd1;
  localparam logic [2:0] K_BLK   = 3'd2;
  localparam logic [2:0] K_RST   = 3'd3;
  localparam logic [2:0] K_WAKE  = 3'd4;
  localparam logic [2:0] K_REG   = 3'd5;
  localparam logic [2:0] K_TEST  = 3'd6;
  localparam logic [3:0] KEY_NO_TEST = 4'd6;

  logic [SRW-1:0] sr;
  logic [CW-1:0]  cnt;
  logic [1:0]     op_r;
  logic           err_r, pw_bad, page_r;
  logic [DW-1:0]  mem [NB];
  logic [NB-1:0]  lk;

  // password bit index: first password bit is compared with the top bit of the last block
  logic [PIW-1:0] pidx;
  logic           in_pw, pw_ref;
  assign pidx   = PIW'(OPW + DW - 1) - cnt[PIW-1:0];
  assign in_pw  = (cnt >= CW'(OPW)) && (cnt < CW'(OPW + DW));
  assign pw_ref = mem[NB-1][pidx];

  logic [AW-1:0] a_f;
  logic [DW-1:0] dat_f, rd;
  logic          zb_f, lk_f, locked;
  assign a_f    = sr[AW-1:0];
  assign zb_f   = sr[AW];
  assign dat_f  = sr[AW+DW-1:AW];
  assign lk_f   = sr[AW+DW];
  assign rd     = op_r[0] ? '0 : mem[a_f];
  assign locked = lk[a_f] | otp_i | op_r[0];

  logic          d_valid, d_page, d_lock, d_we;
  logic [2:0]    d_kind;
  logic [AW-1:0] d_addr;
  logic [DW-1:0] d_data;
  logic          blk_ok, wr_ok, wk_ok;

  assign blk_ok = !zb_f && ((cnt == CW'(L_DA) && !pwd_en_i) ||
                            (cnt == CW'(L_DAP) && pwd_en_i && !pw_bad));
  assign wr_ok  = (cnt == CW'(L_WR) && !pwd_en_i) ||
                  (cnt == CW'(L_PWR) && pwd_en_i && !pw_bad);
  assign wk_ok  = (cnt == CW'(L_WK)) && pwd_en_i && aor_en_i &&
                  (op_r == 2'b10) && !pw_bad;

  always_comb begin
    d_valid = frame_end_i;
    d_kind  = K_REG;
    d_page  = page_r;
    d_addr  = AW'(1);
    d_data  = '0;
    d_lock  = 1'b0;
    d_we    = 1'b0;
    if (cnt >= CW'(OPW) && op_r[1]) d_page = op_r[0];
    if (!err_r && cnt >= CW'(OPW)) begin
      unique case (op_r)
        2'b00: if (cnt == CW'(OPW)) begin
          d_kind = K_RST; d_page = 1'b0; d_addr = '0;
        end
        2'b01: begin
          if (master_key_i == KEY_NO_TEST) d_valid = 1'b0;
          d_kind = K_TEST; d_addr = '0;
        end
        default: begin
          if (wk_ok) begin
            d_kind = K_WAKE; d_addr = '0;
          end else if (blk_ok) begin
            d_kind = K_BLK; d_addr = a_f; d_data = rd;
          end else if (wr_ok) begin
            d_addr = a_f;
            if (locked) begin
              d_kind = K_BLK; d_data = rd;
            end else begin
              d_kind = K_WRITE; d_data = dat_f; d_lock = lk_f; d_we = frame_end_i;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; op_r <= '0; err_r <= 1'b0; pw_bad <= 1'b0; page_r <= 1'b0;
      cmd_valid_o <= 1'b0; cmd_kind_o <= '0; cmd_addr_o <= '0;
      cmd_data_o <= '0; cmd_lock_o <= 1'b0; lk <= '0;
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else begin
      if (frame_end_i) begin
        cnt <= '0; op_r <= '0; err_r <= 1'b0; pw_bad <= 1'b0;
      end else begin
        if (frame_err_i) err_r <= 1'b1;
        if (bit_valid_i) begin
          sr <= {sr[SRW-2:0], bit_i};
          if (cnt != '1) cnt <= cnt + CW'(1);
          if (cnt == CW'(0)) op_r[1] <= bit_i;
          if (cnt == CW'(1)) op_r[0] <= bit_i;
          if (pwd_en_i && in_pw && (bit_i != pw_ref)) pw_bad <= 1'b1;
        end
      end
      cmd_valid_o <= d_valid;
      if (d_valid) begin
        cmd_kind_o <= d_kind; cmd_addr_o <= d_addr;
        cmd_data_o <= d_data; cmd_lock_o <= d_lock; page_r <= d_page;
      end
      if (d_we) begin
        mem[a_f] <= dat_f; lk[a_f] <= lk_f;
      end
    end
  end

  assign cmd_page_o = page_r;

  p_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(frame_end_i));
  p_kind_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_kind_o >= K_WRITE && cmd_kind_o <= K_TEST));
  p_write_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_kind_o == K_WRITE) |->
      (mem[cmd_addr_o] == cmd_data_o && lk[cmd_addr_o] == cmd_lock_o));
  p_write_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_kind_o == K_WRITE) |-> ($past(!otp_i) && !cmd_page_o));
  p_test_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_kind_o == K_TEST) |-> ($past(master_key_i) != KEY_NO_TEST));
  p_reset_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_kind_o == K_RST) |-> !cmd_page_o);
  p_wake_modes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_kind_o == K_WAKE) |-> $past(pwd_en_i && aor_en_i));
endmodule

// File: tb/tb_tag_cmd_parser.sv
`timescale 1ns/1ps
module tb_tag_cmd_parser;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_valid_i = 0, bit_i = 0, frame_end_i = 0, frame_err_i = 0;
  logic pwd_en_i = 0, aor_en_i = 0, otp_i = 0;
  logic [3:0] master_key_i = 4'd0;
  logic cmd_valid_o, cmd_page_o, cmd_lock_o;
  logic [2:0] cmd_kind_o, cmd_addr_o;
  logic [31:0] cmd_data_o;

  int checks = 0, errors = 0;
  bit done = 0;
  localparam logic [31:0] PW = 32'hA5C3_1E77;

  always #4 clk = ~clk;

  tag_cmd_parser dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [69:0] f_wr(input logic [1:0] op, input logic l, input logic [31:0] d, input logic [2:0] a);
    return {32'b0, op, l, d, a};
  endfunction
  function automatic logic [69:0] f_pwr(input logic [1:0] op, input logic [31:0] p, input logic l, input logic [31:0] d, input logic [2:0] a);
    return {op, p, l, d, a};
  endfunction
  function automatic logic [69:0] f_da(input logic [1:0] op, input logic [2:0] a);
    return {64'b0, op, 1'b0, a};
  endfunction
  function automatic logic [69:0] f_dap(input logic [1:0] op, input logic [31:0] p, input logic [2:0] a);
    return {32'b0, op, p, 1'b0, a};
  endfunction
  function automatic logic [69:0] f_wk(input logic [1:0] op, input logic [31:0] p);
    return {36'b0, op, p};
  endfunction

  // sends n bits first bit = v[n-1], closes the frame, checks the one-cycle decision
  task automatic frame(input string req, input logic [69:0] v, input int n, input int err_at,
                       input logic exp_v, input logic [2:0] kind, input logic page,
                       input logic [2:0] addr, input logic [31:0] data, input logic lock);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      bit_valid_i = 1'b1; bit_i = v[i]; frame_err_i = (i == err_at);
    end
    @(negedge clk);
    bit_valid_i = 1'b0; frame_err_i = 1'b0; frame_end_i = 1'b1;
    @(negedge clk);
    frame_end_i = 1'b0;
    chk(req, "valid", 64'(cmd_valid_o), 64'(exp_v));
    if (exp_v) begin
      chk(req, "kind", 64'(cmd_kind_o), 64'(kind));
      chk(req, "page", 64'(cmd_page_o), 64'(page));
      if (kind != 3'd6) chk(req, "addr", 64'(cmd_addr_o), 64'(addr));
      if (kind == 3'd1 || kind == 3'd2) chk(req, "data", 64'(cmd_data_o), 64'(data));
      if (kind == 3'd1) chk(req, "lock", 64'(cmd_lock_o), 64'(lock));
    end
    @(negedge clk);
    chk("R9", "pulse width", 64'(cmd_valid_o), 64'd0);
  endtask

  task automatic t_reset_state;
    chk("R9", "idle after reset", 64'(cmd_valid_o), 64'd0);
    frame("R1", 70'b00, 2, -1, 1, 3'd3, 0, 0, 0, 0);
  endtask

  task automatic t_std_write;
    frame("R2", f_wr(2'b10, 0, PW, 3'd7), 38, -1, 1, 3'd1, 0, 3'd7, PW, 0);
    frame("R2", f_wr(2'b10, 1, 32'h1234_5678, 3'd2), 38, -1, 1, 3'd1, 0, 3'd2, 32'h1234_5678, 1);
  endtask

  task automatic t_direct;
    frame("R3", f_da(2'b10, 3'd7), 6, -1, 1, 3'd2, 0, 3'd7, PW, 0);
    frame("R3", f_da(2'b11, 3'd7), 6, -1, 1, 3'd2, 1, 3'd7, 0, 0);
  endtask

  task automatic t_locked;
    frame("R7", f_wr(2'b10, 0, 32'hDEAD_BEEF, 3'd2), 38, -1, 1, 3'd2, 0, 3'd2, 32'h1234_5678, 0);
    otp_i = 1;
    frame("R7", f_wr(2'b10, 0, 32'h0BAD_F00D, 3'd3), 38, -1, 1, 3'd2, 0, 3'd3, 0, 0);
    otp_i = 0;
    frame("R7", f_da(2'b10, 3'd3), 6, -1, 1, 3'd2, 0, 3'd3, 0, 0);
    frame("R7", f_wr(2'b11, 0, 32'h5555_AAAA, 3'd5), 38, -1, 1, 3'd2, 1, 3'd5, 0, 0);
  endtask

  task automatic t_bad_frames;
    frame("R6", 70'b1101011, 7, -1, 1, 3'd5, 1, 3'd1, 0, 0);
    frame("R6", f_da(2'b10, 3'd7), 6, 2, 1, 3'd5, 0, 3'd1, 0, 0);
  endtask

  task automatic t_password;
    pwd_en_i = 1;
    frame("R4", f_dap(2'b10, PW, 3'd7), 38, -1, 1, 3'd2, 0, 3'd7, PW, 0);
    frame("R6", f_dap(2'b10, PW ^ 32'h8000_0000, 3'd7), 38, -1, 1, 3'd5, 0, 3'd1, 0, 0);
    frame("R4", f_pwr(2'b10, PW, 0, 32'hCAFE_0001, 3'd4), 70, -1, 1, 3'd1, 0, 3'd4, 32'hCAFE_0001, 0);
    frame("R4", f_dap(2'b10, PW, 3'd4), 38, -1, 1, 3'd2, 0, 3'd4, 32'hCAFE_0001, 0);
    frame("R6", f_da(2'b10, 3'd4), 6, -1, 1, 3'd5, 0, 3'd1, 0, 0);
    frame("R6", f_pwr(2'b11, PW ^ 32'h1, 0, 32'h1, 3'd4), 70, -1, 1, 3'd5, 1, 3'd1, 0, 0);
  endtask

  task automatic t_wake;
    aor_en_i = 1;
    frame("R5", f_wk(2'b10, PW), 34, -1, 1, 3'd4, 0, 0, 0, 0);
    frame("R5", f_wk(2'b10, PW ^ 32'h0001_0000), 34, -1, 1, 3'd5, 0, 3'd1, 0, 0);
    frame("R5", f_wk(2'b11, PW), 34, -1, 1, 3'd5, 1, 3'd1, 0, 0);
    aor_en_i = 0;
    frame("R5", f_wk(2'b10, PW), 34, -1, 1, 3'd5, 0, 3'd1, 0, 0);
    pwd_en_i = 0;
  endtask

  task automatic t_test_mode;
    master_key_i = 4'd6;
    frame("R8", 70'b01, 2, -1, 0, 0, 0, 0, 0, 0);
    master_key_i = 4'd9;
    frame("R8", 70'b01, 2, -1, 1, 3'd6, 0, 0, 0, 0);
    master_key_i = 4'd0;
  endtask

  task automatic t_page;
    frame("R10", 70'b11, 2, -1, 1, 3'd5, 1, 3'd1, 0, 0);
    frame("R10", 70'b0, 0, -1, 1, 3'd5, 1, 3'd1, 0, 0);
    frame("R1", 70'b00, 2, -1, 1, 3'd3, 0, 0, 0, 0);
    frame("R10", 70'b1, 1, -1, 1, 3'd5, 0, 3'd1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_std_write();
    t_direct();
    t_locked();
    t_bad_frames();
    t_password();
    t_wake();
    t_test_mode();
    t_page();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule